// File: doc/BRIEF.md
# Qualified Sticky Sense and Enable Register

This block is a small user register that watches three external sense lines and drives three external enable lines. Each sense line first passes through a synchroniser. A run-length qualifier then checks it, so a level counts only after it has been held for a minimum number of consecutive clock samples. A qualified level sets a sticky sense bit. That bit stays set after the line drops and clears only when software writes a 1 to it. The three enable bits are loaded by a register write and drive the enable pins directly. An event flag, the OR of the sense bits, is offered to an interrupt controller.

Software reaches the register through one select strobe, a write qualifier, a write data bus and a registered read data bus. Bits 2:0 of the register image are the sense bits and bits 5:3 are the enable bits. The upper bits read as zero. The intended clock is 12.5 MHz, where two consecutive qualified samples span the required 160 ns of assertion. Every length is a parameter.

Top module: `sticky_sense_reg`

## Requirements
- R1: After a synchronous reset, all sense bits, enable bits, `enable_out`, `event_out` and `rd_data` are zero.
- R2: A sense input that is sampled high on fewer than QUAL_CYCLES consecutive clock edges never sets its sense bit.
- R3: A sense input that is sampled high on QUAL_CYCLES consecutive edges sets its sense bit. The bit becomes 1 at the SYNC_STAGES-th edge after the last of those samples.
- R4: Once set, a sense bit stays 1 after its input goes low, until software clears it.
- R5: A write (`sel`=1, `wr`=1) clears every sense bit i for which `wr_data[i]`=1 (bits 2:0) and leaves sense bits written with 0 unchanged.
- R6: If a qualified input and a clearing write hit the same sense bit in the same cycle, the bit ends up 1.
- R7: A write loads `wr_data[5:3]` into the enable bits. `enable_out[i]` equals enable bit i from the write edge onward (1 = asserted).
- R8: `event_out` is 1 exactly when at least one sense bit is 1, in the same cycle as the sense bits.
- R9: With `sel`=0 or `wr`=0, no enable bit changes and no sense bit is cleared.
- R10: A read (`sel`=1, `wr`=0) loads `rd_data` at that edge with {zeros, enable[2:0], sense[2:0]} as they stood before the edge. Otherwise `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_in | input | CH | Asynchronous external sense lines, active high |
| sel | input | 1 | Register select strobe |
| wr | input | 1 | 1 = write, 0 = read when selected |
| wr_data | input | DW | Write data: [CH-1:0] write-1-to-clear sense, [2CH-1:CH] enables |
| rd_data | output | DW | Registered read data |
| enable_out | output | CH | Enable pins, active high |
| event_out | output | 1 | Interrupt event flag, OR of the sense bits |

## Verification
A stuck or wrongly cleared sense bit appears on `event_out` in the cycle where the correct state would differ. It also appears in the low three bits of `rd_data` one edge after the next read. A qualifier that counts wrongly shows as a sense bit that rises one edge early or late, or that rises at all after a pulse that is one sample too short. A corrupt enable bit is visible on `enable_out` at once. The bench therefore compares all three outputs against a behavioural model on every cycle, and it also makes directed checks of short pulses, sticky retention and a clear that lands in the same cycle as a set.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  // Default geometry of the user register
  parameter int unsigned DEF_CH    = 3;  // sense/enable channel count
  parameter int unsigned DEF_SYNC  = 2;  // synchroniser depth
  parameter int unsigned DEF_QUAL  = 2;  // consecutive samples to qualify
  parameter int unsigned DEF_DW    = 8;  // register data width

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ssr_qualifier.sv
module ssr_qualifier #(
  parameter int unsigned QUAL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic qualified
);
  localparam int unsigned CW = ssr_pkg::cnt_width(QUAL);
  localparam logic [CW-1:0] LAST = CW'(QUAL - 1);
  localparam logic [CW-1:0] SAT  = CW'(QUAL);

  logic [CW-1:0] run_q;

  // run_q counts earlier consecutive high samples, saturating
  always_ff @(posedge clk) begin
    if (rst)            run_q <= '0;
    else if (!level)    run_q <= '0;
    else if (run_q != SAT) run_q <= run_q + 1'b1;
  end

  assign qualified = level && (run_q >= LAST);
endmodule

// File: rtl/ssr_bank.sv
module ssr_bank #(
  parameter int unsigned CH = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic [CH-1:0] qual,
  output logic [CH-1:0] sense_q,
  output logic [CH-1:0] en_q,
  output logic          event_q
);
  logic [CH-1:0] clr_mask;
  logic [CH-1:0] sense_n;

  assign clr_mask = wr_stb ? wr_data[CH-1:0] : '0;
  // set has priority over a same-cycle clear
  assign sense_n  = (sense_q & ~clr_mask) | qual;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      en_q    <= '0;
      event_q <= 1'b0;
    end else begin
      sense_q <= sense_n;
      event_q <= |sense_n;
      if (wr_stb) en_q <= wr_data[2*CH-1:CH];
    end
  end
endmodule

// File: rtl/sticky_sense_reg.sv
module sticky_sense_reg #(
  parameter int unsigned CH   = ssr_pkg::DEF_CH,
  parameter int unsigned SYNC = ssr_pkg::DEF_SYNC,
  parameter int unsigned QUAL = ssr_pkg::DEF_QUAL,
  parameter int unsigned DW   = ssr_pkg::DEF_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] sense_in,
  input  logic          sel,
  input  logic          wr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [CH-1:0] enable_out,
  output logic          event_out
);
  localparam int unsigned IMG_W = 2 * CH;

  logic [CH-1:0] synced;
  logic [CH-1:0] qual;
  logic [CH-1:0] sense_q;
  logic [CH-1:0] en_q;
  logic          wr_stb;
  logic          rd_stb;
  logic [IMG_W-1:0] image;

  generate
    for (genvar i = 0; i < CH; i++) begin : g_ch
      ssr_sync #(.STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sense_in[i]),
        .dout (synced[i])
      );
      ssr_qualifier #(.QUAL(QUAL)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .level     (synced[i]),
        .qualified (qual[i])
      );
    end
  endgenerate

  assign wr_stb = sel && wr;
  assign rd_stb = sel && !wr;

  ssr_bank #(.CH(CH), .DW(DW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .qual    (qual),
    .sense_q (sense_q),
    .en_q    (en_q),
    .event_q (event_out)
  );

  assign image      = {en_q, sense_q};
  assign enable_out = en_q;

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= DW'(image);
  end
endmodule

// File: rtl/sticky_sense_reg_chk.sv
module sticky_sense_reg_chk #(
  parameter int unsigned CH = 3,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sel,
  input logic          wr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic [CH-1:0] enable_out,
  input logic          event_out,
  input logic [CH-1:0] sense_q,
  input logic [CH-1:0] qual
);
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sense_q & $past(sense_q & ~((sel && wr) ? wr_data[CH-1:0] : '0)))
              == $past(sense_q & ~((sel && wr) ? wr_data[CH-1:0] : '0))));

  a_r2_no_unqualified_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sense_q & ~$past(sense_q) & ~$past(qual)) == '0));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|qual) |=> ((sense_q & $past(qual)) == $past(qual)));

  a_r8_event: assert property (@(posedge clk) disable iff (rst)
    event_out == (|sense_q));

  a_r9_enable_hold: assert property (@(posedge clk) disable iff (rst)
    !(sel && wr) |=> $stable(enable_out));

  a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !(sel && !wr) |=> $stable(rd_data));
endmodule

bind sticky_sense_reg sticky_sense_reg_chk #(.CH(CH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel        (sel),
  .wr         (wr),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .enable_out (enable_out),
  .event_out  (event_out),
  .sense_q    (sense_q),
  .qual       (qual)
);

// File: tb/sticky_sense_reg_test.sv
`timescale 1ns/1ps
module sticky_sense_reg_test;
  localparam int CH = 3;
  localparam int DW = 8;
  localparam int QUAL = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CH-1:0] sense_in = '0;
  logic          sel = 1'b0;
  logic          wr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [CH-1:0] enable_out;
  logic          event_out;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sticky_sense_reg uut (
    .clk(clk), .rst(rst), .sense_in(sense_in), .sel(sel), .wr(wr),
    .wr_data(wr_data), .rd_data(rd_data), .enable_out(enable_out),
    .event_out(event_out)
  );

  // behavioural reference model
  int            run [CH];
  logic [CH-1:0] m_sense, m_en, dly1, dly2, qnow, clr;
  logic [DW-1:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CH; i++) run[i] = 0;
      m_sense = '0; m_en = '0; dly1 = '0; dly2 = '0; m_rd = '0;
    end else begin
      if (sel && !wr) m_rd = {2'b00, m_en, m_sense};
      clr = (sel && wr) ? wr_data[CH-1:0] : '0;
      m_sense = (m_sense & ~clr) | dly2;
      if (sel && wr) m_en = wr_data[2*CH-1:CH];
      for (int i = 0; i < CH; i++) begin
        run[i] = sense_in[i] ? run[i] + 1 : 0;
        qnow[i] = (run[i] >= QUAL);
      end
      dly2 = dly1;
      dly1 = qnow;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R7 enable_out vs model", int'(enable_out), int'(m_en));
      check("R8 event_out vs model", int'(event_out), int'(|m_sense));
      check("R10 rd_data vs model", int'(rd_data), int'(m_rd));
    end
  end

  task automatic reg_write(input logic [DW-1:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; wr_data = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0; wr_data = '0;
  endtask

  task automatic reg_read(output logic [DW-1:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0;
    @(negedge clk); sel = 1'b0; d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [DW-1:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 enable_out after reset", int'(enable_out), 0);
    check("R1 event_out after reset", int'(event_out), 0);
    check("R1 rd_data after reset", int'(rd_data), 0);
    reg_read(v);
    check("R1 register image after reset", int'(v), 0);

    // R2: one-sample pulse on channel 0 does not latch
    @(negedge clk); sense_in[0] = 1'b1;
    @(negedge clk); sense_in[0] = 1'b0;
    idle(6);
    reg_read(v);
    check("R2 short pulse ignored", int'(v), 0);
    check("R2 no event after short pulse", int'(event_out), 0);

    // R3: two-sample pulse on channel 1 latches, with latency of 2 edges
    @(negedge clk); sense_in[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); sense_in[1] = 1'b0;   // samples at two edges
    check("R3 not yet set after 0 extra edges", int'(event_out), 0);
    @(negedge clk);
    check("R3 not yet set after 1 extra edge", int'(event_out), 0);
    @(negedge clk);
    check("R3 set at second edge after last sample", int'(event_out), 1);
    // R4: sticky after deassert
    idle(8);
    reg_read(v);
    check("R4 sense bit stays after input low", int'(v), 8'h02);

    // R5 + R7: clear bit 1, load enables 101
    reg_write(8'b00_101_010);
    check("R7 enable_out loaded", int'(enable_out), 3'b101);
    check("R5 event clears after write-1", int'(event_out), 0);
    reg_read(v);
    check("R5 image after clear", int'(v), 8'h28);

    // R9: write data with sel low, and read with wr low, do nothing
    @(negedge clk); sel = 1'b0; wr = 1'b1; wr_data = 8'hFF;
    @(negedge clk); wr = 1'b0; wr_data = '0;
    check("R9 enables hold with sel low", int'(enable_out), 3'b101);

    // R6: channel 2 held high, clear in the same cycle as the set
    @(negedge clk); sense_in[2] = 1'b1;
    idle(6);
    check("R8 event from channel 2", int'(event_out), 1);
    reg_write(8'b00_101_100);
    reg_read(v);
    check("R6 set wins over clear", int'(v), 8'h2C);
    @(negedge clk); sense_in[2] = 1'b0;
    idle(4);
    reg_write(8'b00_010_100);
    check("R7 enable_out reloaded", int'(enable_out), 3'b010);
    reg_read(v);
    check("R5 channel 2 cleared once low", int'(v), 8'h10);

    // R5: writing 0 to a set bit leaves it; R8 multi-bit OR
    @(negedge clk); sense_in = 3'b011;
    idle(5);
    sense_in = 3'b000;
    idle(3);
    reg_write(8'b00_010_000);
    reg_read(v);
    check("R5 zero write keeps bits", int'(v), 8'h13);
    reg_write(8'b00_010_001);
    check("R8 event stays with one bit left", int'(event_out), 1);
    reg_write(8'b00_000_010);
    check("R8 event drops when all clear", int'(event_out), 0);
    check("R7 enables cleared", int'(enable_out), 0);

    idle(4);
    summary();
  end
endmodule